// File: doc/BRIEF.md
# Transmit FCS Mode Controller

This block sits in an Ethernet transmit path, after frame data has been fetched from memory and before the MAC. Frames arrive one byte per beat on a valid/ready stream that carries start-of-frame and end-of-frame markers. On the start-of-frame beat, a sideband descriptor gives four things: a 2-bit FCS action, the stored length, the wire length and a sliced flag. For each frame the block does one of three things with the final four bytes. It writes a freshly computed CRC-32 into them, or it writes a CRC-32 that has been deliberately damaged, or it lets the stored bytes through untouched.

Admission is decided on the start-of-frame beat from the descriptor alone. A frame is rejected when it is marked sliced, when its wire length and stored length disagree, or when its stored length lies outside the supported window. A rejected frame is still consumed from the input. None of its beats reach the output, and a drop counter advances once for that frame. Accepted frames flow through an output stage that honours backpressure without losing or reordering bytes.

Top module: `tx_fcs_ctrl`

## Requirements
- R1: With FCS action 2'b01, the last four bytes of the frame are replaced by the IEEE 802.3 CRC-32 of all earlier bytes. The polynomial is 0x04C11DB7, processed reflected, with an all-ones start value and a final inversion. The first replaced byte carries CRC bits 7:0 and the last carries bits 31:24.
- R2: With FCS action 2'b10, the last four bytes are replaced by the R1 value XORed with 0x00000001.
- R3: With FCS action 2'b00 or 2'b11, the last four bytes leave exactly as they arrived.
- R4: All bytes before the last four leave unchanged and in order. Start-of-frame and end-of-frame markers stay on the same bytes.
- R5: A frame whose sliced flag is 1 is dropped whole.
- R6: A frame whose wire length differs from its stored length is dropped whole.
- R7: A frame with stored length above MAX_FRAME (default 10000) is dropped whole. A frame of exactly MAX_FRAME is kept.
- R8: A frame with stored length below MIN_FRAME (default 64) is dropped whole. A frame of exactly MIN_FRAME is kept.
- R9: Every beat of a dropped frame is accepted, and none of them appears on the output. `drop_count` rises by exactly one in the cycle after the start-of-frame beat of a dropped frame is accepted. It does not change for a kept frame.
- R10: While `out_valid` is high and `out_ready` is low, the output beat is held stable. No accepted byte is lost or duplicated.
- R11: After reset, `out_valid` is 0 and `drop_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | 8 | Input frame byte |
| in_sof | input | 1 | First byte of a frame; descriptor fields are valid on this beat |
| in_eof | input | 1 | Last byte of a frame |
| in_fcs_mode | input | 2 | FCS action: 01 correct, 10 corrupted, 00/11 keep stored |
| in_stored_len | input | LEN_W | Stored frame length in bytes, FCS included |
| in_wire_len | input | LEN_W | Wire length in bytes |
| in_sliced | input | 1 | Frame was sliced; it must not be sent |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 8 | Output frame byte |
| out_sof | output | 1 | First byte of an output frame |
| out_eof | output | 1 | Last byte of an output frame |
| drop_count | output | CNT_W | Number of frames dropped since reset |

## Verification
With the registered output stage, each kept byte appears on `out_data` one clock after it is accepted on the input. The bench does not count cycles for data. It pairs each output handshake with the next entry of an expected byte list, so data checks hold under any stall pattern. `drop_count` is due one clock after the start-of-frame beat is accepted. The bench records that acceptance and compares the counter at the next sampling point, half a period before the following edge. All inputs change just after a falling edge, and both handshakes are sampled shortly before the rising edge.

// File: rtl/tx_fcs_pkg.sv
package tx_fcs_pkg;

   typedef enum logic [1:0] {
      FCS_KEEP     = 2'b00,
      FCS_GOOD     = 2'b01,
      FCS_BAD      = 2'b10,
      FCS_KEEP_ALT = 2'b11
   } fcs_mode_e;

   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

   // One byte of reflected CRC-32, bit serial, LSB first.
   function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int b = 0; b < 8; b++) begin
         if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/tx_fcs_admit.sv
module tx_fcs_admit #(
   parameter int LEN_W     = 14,
   parameter int MIN_FRAME = 64,
   parameter int MAX_FRAME = 10000
) (
   input  logic [LEN_W-1:0] stored_len,
   input  logic [LEN_W-1:0] wire_len,
   input  logic             sliced,
   output logic             reject
);
   localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
   localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);

   logic len_mismatch;
   logic too_long;
   logic too_short;

   always_comb begin
      len_mismatch = (stored_len != wire_len);
      too_long     = (stored_len > MAX_L);
      too_short    = (stored_len < MIN_L);
      reject       = sliced | len_mismatch | too_long | too_short;
   end
endmodule

// File: rtl/tx_fcs_crc.sv
module tx_fcs_crc
   import tx_fcs_pkg::*;
#(
   parameter logic [31:0] CORRUPT_MASK = 32'h0000_0001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        restart,
   input  logic        advance,
   input  logic [7:0]  data,
   output logic [31:0] fcs_good,
   output logic [31:0] fcs_bad
);
   logic [31:0] crc_q;
   logic [31:0] crc_base;

   always_comb begin
      crc_base = restart ? CRC_SEED : crc_q;
      fcs_good = ~crc_base;
      fcs_bad  = ~crc_base ^ CORRUPT_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       crc_q <= CRC_SEED;
      else if (advance) crc_q <= crc32_step(crc_base, data);
   end
endmodule

// File: rtl/tx_fcs_outstage.sv
module tx_fcs_outstage #(
   parameter int  DATA_W  = 8,
   parameter bit  REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [DATA_W-1:0] up_data,
   input  logic              up_sof,
   input  logic              up_eof,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [DATA_W-1:0] dn_data,
   output logic              dn_sof,
   output logic              dn_eof
);
   generate
      if (REG_OUT) begin : g_reg
         logic              v_q;
         logic [DATA_W-1:0] d_q;
         logic              s_q;
         logic              e_q;

         assign up_ready = !v_q || dn_ready;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               d_q <= '0;
               s_q <= 1'b0;
               e_q <= 1'b0;
            end else if (up_ready) begin
               v_q <= up_valid;
               if (up_valid) begin
                  d_q <= up_data;
                  s_q <= up_sof;
                  e_q <= up_eof;
               end
            end
         end

         assign dn_valid = v_q;
         assign dn_data  = d_q;
         assign dn_sof   = s_q;
         assign dn_eof   = e_q;
      end else begin : g_wire
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign up_ready = dn_ready;
         assign dn_valid = up_valid;
         assign dn_data  = up_data;
         assign dn_sof   = up_sof;
         assign dn_eof   = up_eof;
      end
   endgenerate
endmodule

// File: rtl/tx_fcs_ctrl.sv
module tx_fcs_ctrl
   import tx_fcs_pkg::*;
#(
   parameter int          LEN_W        = 14,
   parameter int          MIN_FRAME    = 64,
   parameter int          MAX_FRAME    = 10000,
   parameter int          CNT_W        = 32,
   parameter logic [31:0] CORRUPT_MASK = 32'h0000_0001,
   parameter bit          REG_OUT      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_data,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic [1:0]       in_fcs_mode,
   input  logic [LEN_W-1:0] in_stored_len,
   input  logic [LEN_W-1:0] in_wire_len,
   input  logic             in_sliced,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_data,
   output logic             out_sof,
   output logic             out_eof,
   output logic [CNT_W-1:0] drop_count
);
   localparam int               FCS_BYTES = 4;
   localparam logic [LEN_W-1:0] FCS_LEN   = LEN_W'(FCS_BYTES);

   generate
      if (MIN_FRAME <= FCS_BYTES) begin : g_bad_min
         $error("MIN_FRAME must exceed the FCS size");
      end
      if (MAX_FRAME < MIN_FRAME) begin : g_bad_range
         $error("MAX_FRAME must not be below MIN_FRAME");
      end
      if (MAX_FRAME >= (1 << LEN_W)) begin : g_bad_width
         $error("LEN_W too narrow for MAX_FRAME");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be positive");
      end
   endgenerate

   // per-frame context, captured on the start-of-frame beat
   logic             drop_q;
   logic [LEN_W-1:0] len_q;
   fcs_mode_e        mode_q;
   logic [LEN_W-1:0] idx_q;

   logic             admit_reject;
   logic             drop_now;
   logic [LEN_W-1:0] len_now;
   fcs_mode_e        mode_now;
   logic [LEN_W-1:0] idx_now;
   logic [LEN_W-1:0] tail_start;
   logic             in_tail;
   logic [1:0]       tail_sel;
   logic             fire;
   logic             st_valid;
   logic             st_ready;
   logic [7:0]       st_data;
   logic [31:0]      fcs_good;
   logic [31:0]      fcs_bad;
   logic [31:0]      fcs_pick;
   logic             crc_adv;

   tx_fcs_admit #(
      .LEN_W     (LEN_W),
      .MIN_FRAME (MIN_FRAME),
      .MAX_FRAME (MAX_FRAME)
   ) admit_i (
      .stored_len (in_stored_len),
      .wire_len   (in_wire_len),
      .sliced     (in_sliced),
      .reject     (admit_reject)
   );

   always_comb begin
      drop_now   = in_sof ? admit_reject : drop_q;
      len_now    = in_sof ? in_stored_len : len_q;
      mode_now   = in_sof ? fcs_mode_e'(in_fcs_mode) : mode_q;
      idx_now    = in_sof ? '0 : idx_q;
      tail_start = len_now - FCS_LEN;
      in_tail    = (idx_now >= tail_start);
      tail_sel   = 2'(idx_now - tail_start);
      in_ready   = drop_now | st_ready;
      fire       = in_valid & in_ready;
      st_valid   = in_valid & ~drop_now;
      crc_adv    = fire & ~drop_now & ~in_tail;
   end

   tx_fcs_crc #(
      .CORRUPT_MASK (CORRUPT_MASK)
   ) crc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (in_sof),
      .advance  (crc_adv),
      .data     (in_data),
      .fcs_good (fcs_good),
      .fcs_bad  (fcs_bad)
   );

   always_comb begin
      fcs_pick = (mode_now == FCS_BAD) ? fcs_bad : fcs_good;
      st_data  = in_data;
      if (in_tail && (mode_now == FCS_GOOD || mode_now == FCS_BAD)) begin
         st_data = fcs_pick[{tail_sel, 3'b000} +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drop_q     <= 1'b1;
         len_q      <= '0;
         mode_q     <= FCS_KEEP;
         idx_q      <= '0;
         drop_count <= '0;
      end else if (fire) begin
         if (in_sof) begin
            drop_q <= admit_reject;
            len_q  <= in_stored_len;
            mode_q <= fcs_mode_e'(in_fcs_mode);
            idx_q  <= LEN_W'(1);
            if (admit_reject) drop_count <= drop_count + 1'b1;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
         // beats outside any frame are discarded
         if (in_eof) drop_q <= 1'b1;
      end
   end

   tx_fcs_outstage #(
      .DATA_W  (8),
      .REG_OUT (REG_OUT)
   ) out_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (st_valid),
      .up_ready (st_ready),
      .up_data  (st_data),
      .up_sof   (in_sof),
      .up_eof   (in_eof),
      .dn_valid (out_valid),
      .dn_ready (out_ready),
      .dn_data  (out_data),
      .dn_sof   (out_sof),
      .dn_eof   (out_eof)
   );
endmodule

// File: rtl/tx_fcs_ctrl_chk.sv
module tx_fcs_ctrl_chk #(
   parameter int LEN_W     = 14,
   parameter int MIN_FRAME = 64,
   parameter int MAX_FRAME = 10000,
   parameter int CNT_W     = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             in_sof,
   input logic [LEN_W-1:0] in_stored_len,
   input logic [LEN_W-1:0] in_wire_len,
   input logic             in_sliced,
   input logic             out_valid,
   input logic             out_ready,
   input logic [7:0]       out_data,
   input logic             out_sof,
   input logic             out_eof,
   input logic [CNT_W-1:0] drop_count
);
   localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
   localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   logic sof_fire;
   logic good_desc;
   assign sof_fire  = in_valid && in_ready && in_sof;
   assign good_desc = !in_sliced && (in_stored_len == in_wire_len) &&
                      (in_stored_len <= MAX_L) && (in_stored_len >= MIN_L);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof));

   p_sliced_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sof_fire && in_sliced |=> drop_count == $past(drop_count) + ONE);

   p_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sof_fire && (in_stored_len != in_wire_len) |=> drop_count == $past(drop_count) + ONE);

   p_oversize_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sof_fire && (in_stored_len > MAX_L) |=> drop_count == $past(drop_count) + ONE);

   p_undersize_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sof_fire && (in_stored_len < MIN_L) |=> drop_count == $past(drop_count) + ONE);

   p_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sof_fire && good_desc |=> drop_count == $past(drop_count));

   p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sof_fire |=> drop_count == $past(drop_count));

   p_reset_r11: assert property (@(posedge clk)
      $past(!rst_n) |-> !out_valid && drop_count == '0);
endmodule

bind tx_fcs_ctrl tx_fcs_ctrl_chk #(
   .LEN_W     (LEN_W),
   .MIN_FRAME (MIN_FRAME),
   .MAX_FRAME (MAX_FRAME),
   .CNT_W     (CNT_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_ready      (in_ready),
   .in_sof        (in_sof),
   .in_stored_len (in_stored_len),
   .in_wire_len   (in_wire_len),
   .in_sliced     (in_sliced),
   .out_valid     (out_valid),
   .out_ready     (out_ready),
   .out_data      (out_data),
   .out_sof       (out_sof),
   .out_eof       (out_eof),
   .drop_count    (drop_count)
);

// File: tb/tx_fcs_ctrl_tb_top.sv
module tx_fcs_ctrl_tb_top;
   localparam int LEN_W = 14;
   localparam int MINF  = 64;
   localparam int MAXF  = 100;
   localparam int CNT_W = 16;
   localparam int DEPTH = 8192;
   localparam int WD    = 100000;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             in_valid;
   logic             in_ready;
   logic [7:0]       in_data;
   logic             in_sof;
   logic             in_eof;
   logic [1:0]       in_fcs_mode;
   logic [LEN_W-1:0] in_stored_len;
   logic [LEN_W-1:0] in_wire_len;
   logic             in_sliced;
   logic             out_valid;
   logic             out_ready;
   logic [7:0]       out_data;
   logic             out_sof;
   logic             out_eof;
   logic [CNT_W-1:0] drop_count;

   always #4 clk = ~clk;

   tx_fcs_ctrl #(
      .LEN_W     (LEN_W),
      .MIN_FRAME (MINF),
      .MAX_FRAME (MAXF),
      .CNT_W     (CNT_W)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_ready      (in_ready),
      .in_data       (in_data),
      .in_sof        (in_sof),
      .in_eof        (in_eof),
      .in_fcs_mode   (in_fcs_mode),
      .in_stored_len (in_stored_len),
      .in_wire_len   (in_wire_len),
      .in_sliced     (in_sliced),
      .out_valid     (out_valid),
      .out_ready     (out_ready),
      .out_data      (out_data),
      .out_sof       (out_sof),
      .out_eof       (out_eof),
      .drop_count    (drop_count)
   );

   // stimulus beats
   logic [7:0]       s_data [DEPTH];
   logic             s_sof  [DEPTH];
   logic             s_eof  [DEPTH];
   logic [1:0]       s_mode [DEPTH];
   logic [LEN_W-1:0] s_slen [DEPTH];
   logic [LEN_W-1:0] s_wlen [DEPTH];
   logic             s_sl   [DEPTH];
   int               s_frm  [DEPTH];
   int               ns = 0;
   // expected output beats
   logic [7:0]       e_data [DEPTH];
   logic             e_sof  [DEPTH];
   logic             e_eof  [DEPTH];
   string            e_tag  [DEPTH];
   int               ne = 0;
   // per-frame drop bookkeeping
   int               f_cum  [64];
   string            f_tag  [64];
   int               nf = 0;
   int               drops = 0;

   int               checks = 0;
   int               fails  = 0;
   logic [31:0]      lcg = 32'h1234_5678;

   function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'h0, d};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
      return r;
   endfunction

   task automatic add_frame(input int len, input int wlen, input logic [1:0] mode,
                            input logic sliced, input string dtag);
      logic        drop;
      logic [31:0] crc;
      logic [31:0] fcs;
      logic [7:0]  b;
      drop = sliced || (len != wlen) || (len > MAXF) || (len < MINF);
      crc  = 32'hFFFF_FFFF;
      fcs  = 32'h0;
      for (int i = 0; i < len; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         b   = lcg[23:16];
         s_data[ns] = b;
         s_sof[ns]  = (i == 0);
         s_eof[ns]  = (i == len - 1);
         s_mode[ns] = mode;
         s_slen[ns] = LEN_W'(len);
         s_wlen[ns] = LEN_W'(wlen);
         s_sl[ns]   = sliced;
         s_frm[ns]  = nf;
         ns++;
         if (!drop) begin
            e_sof[ne] = (i == 0);
            e_eof[ne] = (i == len - 1);
            if (i < len - 4) begin
               crc = ref_crc(crc, b);
               e_data[ne] = b;
               e_tag[ne]  = "R4 R10";
            end else begin
               if (i == len - 4) fcs = ~crc;
               if (mode == 2'b01) begin
                  e_data[ne] = fcs[8*(i-(len-4)) +: 8];
                  e_tag[ne]  = "R1";
               end else if (mode == 2'b10) begin
                  e_data[ne] = (fcs ^ 32'h1) >> (8*(i-(len-4)));
                  e_tag[ne]  = "R2";
               end else begin
                  e_data[ne] = b;
                  e_tag[ne]  = "R3";
               end
            end
            ne++;
         end
      end
      if (drop) drops++;
      f_cum[nf] = drops;
      f_tag[nf] = drop ? dtag : "R9";
      nf++;
   endtask

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   initial begin
      int lens [5] = '{64, 65, 67, 99, 100};
      int sp  = 0;
      int ep  = 0;
      int cyc = 0;
      int pend = -1;
      logic give;

      for (int m = 0; m < 4; m++)
         for (int l = 0; l < 5; l++) add_frame(lens[l], lens[l], 2'(m), 1'b0, "R9");
      add_frame(70, 70, 2'b01, 1'b1, "R5");
      add_frame(72, 73, 2'b01, 1'b0, "R6");
      add_frame(80, 80, 2'b10, 1'b0, "R9");
      add_frame(101, 101, 2'b01, 1'b0, "R7");
      add_frame(150, 150, 2'b00, 1'b0, "R7");
      add_frame(63, 63, 2'b01, 1'b0, "R8");
      add_frame(1, 1, 2'b01, 1'b0, "R8");
      add_frame(90, 90, 2'b10, 1'b1, "R5");
      add_frame(64, 64, 2'b10, 1'b0, "R8");
      add_frame(100, 100, 2'b01, 1'b0, "R7");

      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
      in_data = '0; in_sof = 1'b0; in_eof = 1'b0; in_fcs_mode = '0;
      in_stored_len = '0; in_wire_len = '0; in_sliced = 1'b0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R11", int'(out_valid), 0);
      check(drop_count == '0, "R11", int'(drop_count), 0);
      rst_n = 1'b1;

      while ((sp < ns || ep < ne) && cyc < WD) begin
         @(negedge clk);
         cyc++;
         if (pend >= 0) begin
            check(int'(drop_count) == f_cum[pend], f_tag[pend], int'(drop_count), f_cum[pend]);
            pend = -1;
         end
         give      = (sp < ns) && (cyc % 7 != 3);
         in_valid  = give;
         out_ready = ((cyc * 5) % 11) < 7 && !(cyc % 97 > 90);
         if (give) begin
            in_data = s_data[sp]; in_sof = s_sof[sp]; in_eof = s_eof[sp];
            in_fcs_mode = s_mode[sp]; in_stored_len = s_slen[sp];
            in_wire_len = s_wlen[sp]; in_sliced = s_sl[sp];
         end else begin
            in_sof = 1'b0; in_eof = 1'b0;
         end
         #3;
         if (in_valid && in_ready) begin
            if (s_sof[sp]) pend = s_frm[sp];
            sp++;
         end
         if (out_valid && out_ready) begin
            if (ep >= ne) begin
               check(1'b0, "R9", int'(out_data), 0);
            end else begin
               check(out_data == e_data[ep] && out_sof == e_sof[ep] && out_eof == e_eof[ep],
                     e_tag[ep], int'({out_sof, out_eof, out_data}),
                     int'({e_sof[ep], e_eof[ep], e_data[ep]}));
            end
            ep++;
         end
      end
      in_valid = 1'b0;
      @(negedge clk);
      if (cyc >= WD) check(1'b0, "watchdog", cyc, WD);
      check(int'(drop_count) == drops, "R9", int'(drop_count), drops);
      check(out_valid == 1'b0, "R9", int'(out_valid), 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule